// File: doc/BRIEF.md
# Streaming Window Max-Pool Unit

This block sits on the write side of a data mover and reduces a stream of wide beats over time. Each beat holds a row of signed 8-bit elements grouped into spatial lanes; the default shape is 8 lanes of 8 bytes, 64 bytes in all. The unit keeps an element-wise running maximum over a window of consecutive beats. After the last beat of the window it emits one result beat. With channel-last data of 8 channels per pixel, a beat carries 8 pixels × 8 channels. A window of 9 beats therefore yields 3×3 pooling for 8 output pixels at once.

Upstream logic is expected to deliver the data already padded and ordered window by window. The window length comes from a single 32-bit configuration value. A bypass control turns the unit into a plain wire so the stream passes through unmodified. Both streams use valid/ready handshakes. The result is presented combinationally, together with the final input beat, so the unit adds no cycle of latency.

Top module: `window_maxpool`

## Requirements
- R1: After reset, or when reset is applied part-way through a window, the beat count restarts. The next output appears only after a full new window, and its value depends only on the beats of that window. With no input offered after reset, out_valid is 0 and in_ready is 1.
- R2: With bypass clear, every element of the result is the maximum, over all beats of the window, of the element at the same byte position.
- R3: With bypass clear and window length N ≥ 1, out_valid is asserted only while the N-th beat of a window is offered. After that beat is accepted, counting restarts at the first beat.
- R4: While a beat that is not the last of its window is offered, in_ready is 1 whatever the value of out_ready, and out_valid is 0.
- R5: While the last beat of a window is offered, in_ready equals out_ready. A stalled last beat is held, and the result stays correct once out_ready rises.
- R6: The first beat of a window is loaded into the accumulator as it is, not compared with earlier data. An all-negative window that follows a positive one therefore yields negative maxima.
- R7: With bypass set, out_data equals in_data, out_valid equals in_valid and in_ready equals out_ready, with no windowing.
- R8: A window length of 1 forwards every beat as its own result. A length of 0 is treated as 1.
- R9: Elements are compared as two's complement. 8'h01 beats 8'hFF (−1), and 8'h7F beats 8'h80 (−128).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_win_len | input | 32 | Beats per pooling window (0 acts as 1) |
| cfg_bypass | input | 1 | 1: pass beats through unchanged |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | LANES*LANE_BYTES*ELEM_W (512) | Input beat, byte j at bits 8j+7:8j |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Downstream can take the result |
| out_data | output | LANES*LANE_BYTES*ELEM_W (512) | Result beat, same byte layout |

## Verification
The windowing is tried with several kinds of data. Pseudo-random full-range bytes over windows of 9, 4, 16 and 2 beats exercise the element-wise maximum and show whether every byte position is reduced independently. An all-negative window right after a positive one tells whether the first beat is loaded or compared against stale state. Uniform 8'hFF/8'h01 and 8'h80/8'h7F beats separate a signed comparison from an unsigned one. Window lengths 1 and 0, bypass mode, and a reset in the middle of a window check that the beat count starts over correctly. Each run holds out_ready low first, which confirms that back-pressure only acts on the final beat.

// File: rtl/wmp_pkg.sv
package wmp_pkg;

    localparam int ELEM_W_DEF     = 8;
    localparam int LANE_BYTES_DEF = 8;
    localparam int LANES_DEF      = 8;
    localparam int CFG_W          = 32;

    typedef logic signed [ELEM_W_DEF-1:0] elem_t;

    // Window position of the beat currently offered at the input.
    typedef enum logic [1:0] {
        PH_PASS  = 2'd0,
        PH_ACCUM = 2'd1,
        PH_LAST  = 2'd2
    } phase_e;

    typedef struct packed {
        logic fire;
        logic first;
        logic acc_load;
    } step_t;

    function automatic elem_t elem_max(input elem_t a, input elem_t b);
        return (a > b) ? a : b;
    endfunction

    // Final count index of a window; lengths 0 and 1 both mean one beat.
    function automatic logic [CFG_W-1:0] last_index(input logic [CFG_W-1:0] len);
        return (len <= 1) ? '0 : len - 1'b1;
    endfunction

endpackage

// File: rtl/wmp_lane_max.sv
module wmp_lane_max #(
    parameter int ELEM_W     = 8,
    parameter int LANE_BYTES = 8,
    localparam int LANE_W    = ELEM_W * LANE_BYTES
) (
    input  logic              load_first,
    input  logic [LANE_W-1:0] acc_lane,
    input  logic [LANE_W-1:0] in_lane,
    output logic [LANE_W-1:0] res_lane
);

    for (genvar e = 0; e < LANE_BYTES; e++) begin : g_elem
        logic signed [ELEM_W-1:0] held;
        logic signed [ELEM_W-1:0] fresh;
        logic signed [ELEM_W-1:0] bigger;

        assign held   = acc_lane[e*ELEM_W +: ELEM_W];
        assign fresh  = in_lane[e*ELEM_W +: ELEM_W];
        assign bigger = (held > fresh) ? held : fresh;
        assign res_lane[e*ELEM_W +: ELEM_W] = load_first ? fresh : bigger;
    end

endmodule

// File: rtl/wmp_window_ctrl.sv
module wmp_window_ctrl
    import wmp_pkg::*;
#(
    parameter int CNT_W = CFG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_win_len,
    input  logic             cfg_bypass,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output step_t            step
);

    logic [CNT_W-1:0] beat_cnt;
    logic [CNT_W-1:0] final_idx;
    logic             at_last;
    phase_e           phase;

    assign final_idx = (cfg_win_len <= 1) ? '0 : cfg_win_len - 1'b1;
    assign at_last   = (beat_cnt >= final_idx);

    always_comb begin
        if (cfg_bypass)   phase = PH_PASS;
        else if (at_last) phase = PH_LAST;
        else              phase = PH_ACCUM;
    end

    always_comb begin
        unique case (phase)
            PH_ACCUM: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
            end
            default: begin
                in_ready  = out_ready;
                out_valid = in_valid;
            end
        endcase
    end

    always_comb begin
        step.fire     = in_valid && in_ready;
        step.first    = (beat_cnt == '0);
        step.acc_load = step.fire && (phase == PH_ACCUM);
    end

    always_ff @(posedge clk) begin
        if (rst || cfg_bypass) begin
            beat_cnt <= '0;
        end else if (step.fire) begin
            beat_cnt <= at_last ? '0 : beat_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wmp_accum.sv
module wmp_accum #(
    parameter int BEAT_W = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BEAT_W-1:0] d,
    output logic [BEAT_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

endmodule

// File: rtl/window_maxpool.sv
module window_maxpool
    import wmp_pkg::*;
#(
    parameter int ELEM_W     = ELEM_W_DEF,
    parameter int LANE_BYTES = LANE_BYTES_DEF,
    parameter int LANES      = LANES_DEF,
    localparam int LANE_W    = ELEM_W * LANE_BYTES,
    localparam int BEAT_W    = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  cfg_win_len,
    input  logic              cfg_bypass,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BEAT_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BEAT_W-1:0] out_data
);

    step_t             step;
    logic [BEAT_W-1:0] acc_q;
    logic [BEAT_W-1:0] reduced;

    wmp_window_ctrl #(.CNT_W(CFG_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cfg_win_len (cfg_win_len),
        .cfg_bypass  (cfg_bypass),
        .in_valid    (in_valid),
        .out_ready   (out_ready),
        .in_ready    (in_ready),
        .out_valid   (out_valid),
        .step        (step)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        wmp_lane_max #(.ELEM_W(ELEM_W), .LANE_BYTES(LANE_BYTES)) u_lane (
            .load_first (step.first),
            .acc_lane   (acc_q[l*LANE_W +: LANE_W]),
            .in_lane    (in_data[l*LANE_W +: LANE_W]),
            .res_lane   (reduced[l*LANE_W +: LANE_W])
        );
    end

    wmp_accum #(.BEAT_W(BEAT_W)) u_acc (
        .clk  (clk),
        .rst  (rst),
        .load (step.acc_load),
        .d    (reduced),
        .q    (acc_q)
    );

    assign out_data = cfg_bypass ? in_data : reduced;

endmodule

// File: rtl/wmp_checker.sv
module wmp_checker #(
    parameter int ELEM_W  = 8,
    parameter int NELEM   = 64,
    parameter int CFG_W   = 32,
    localparam int BEAT_W = ELEM_W * NELEM
) (
    input logic              clk,
    input logic              rst,
    input logic [CFG_W-1:0]  cfg_win_len,
    input logic              cfg_bypass,
    input logic              in_valid,
    input logic              in_ready,
    input logic [BEAT_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BEAT_W-1:0] out_data
);

    logic [CFG_W-1:0] seen;
    logic [CFG_W-1:0] eff_len;
    logic             dominates;

    assign eff_len = (cfg_win_len == '0) ? 1 : cfg_win_len;

    always_comb begin
        dominates = 1'b1;
        for (int i = 0; i < NELEM; i++) begin
            if ($signed(out_data[i*ELEM_W +: ELEM_W]) < $signed(in_data[i*ELEM_W +: ELEM_W]))
                dominates = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cfg_bypass)          seen <= '0;
        else if (in_valid && in_ready)  seen <= out_valid ? '0 : seen + 1'b1;
    end

    AST_ACCUM_READY: assert property (@(posedge clk) disable iff (rst)
        (!cfg_bypass && in_valid && !out_valid) |-> in_ready);                 // R4

    AST_FINAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cfg_bypass && out_valid) |-> (in_ready == out_ready));               // R5

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
        cfg_bypass |-> (out_data == in_data && out_valid == in_valid));        // R7

    AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (rst)
        (!cfg_bypass && out_valid) |-> (seen == eff_len - 1));                 // R3

    AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (rst)
        (!cfg_bypass && eff_len == 1 && in_valid) |-> out_valid);             // R8

    AST_RESULT_DOMINATES: assert property (@(posedge clk) disable iff (rst)
        (!cfg_bypass && out_valid) |-> dominates);                            // R2

endmodule

bind window_maxpool wmp_checker #(
    .ELEM_W (ELEM_W),
    .NELEM  (LANES * LANE_BYTES),
    .CFG_W  (wmp_pkg::CFG_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_win_len (cfg_win_len),
    .cfg_bypass  (cfg_bypass),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_data     (in_data),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data)
);

// File: tb/window_maxpool_tb.sv
module window_maxpool_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 64;
    localparam int BW         = NB * 8;

    typedef struct packed {
        logic [31:0] len;
        logic        byp;
        logic [7:0]  seed;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{len: 32'd9,  byp: 1'b0, seed: 8'h05},
        '{len: 32'd9,  byp: 1'b0, seed: 8'h85},
        '{len: 32'd4,  byp: 1'b0, seed: 8'h13},
        '{len: 32'd1,  byp: 1'b0, seed: 8'h22},
        '{len: 32'd3,  byp: 1'b1, seed: 8'h31},
        '{len: 32'd2,  byp: 1'b0, seed: 8'h90},
        '{len: 32'd0,  byp: 1'b0, seed: 8'h47},
        '{len: 32'd16, byp: 1'b0, seed: 8'h5a}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic [31:0]   cfg_win_len;
    logic          cfg_bypass;
    logic          in_valid;
    logic          in_ready;
    logic [BW-1:0] in_data;
    logic          out_valid;
    logic          out_ready;
    logic [BW-1:0] out_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    window_maxpool u_dut (
        .clk(clk), .rst(rst), .cfg_win_len(cfg_win_len), .cfg_bypass(cfg_bypass),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input logic [BW-1:0] act,
                       input logic [BW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] mk_beat(input logic [7:0] seed, input int k);
        logic [BW-1:0] b;
        for (int j = 0; j < NB; j++) begin
            logic [7:0] v;
            v = 8'(seed * 29 + j * 41 + k * 97 + j * k);
            if (seed[7]) v[7] = 1'b1;
            b[j*8 +: 8] = v;
        end
        return b;
    endfunction

    function automatic logic [BW-1:0] smax(input logic [BW-1:0] a, input logic [BW-1:0] b);
        logic [BW-1:0] r;
        for (int j = 0; j < NB; j++)
            r[j*8 +: 8] = ($signed(a[j*8 +: 8]) > $signed(b[j*8 +: 8])) ? a[j*8 +: 8] : b[j*8 +: 8];
        return r;
    endfunction

    // Offers one window; each beat is first shown with out_ready low.
    task automatic run_window(input int len, input bit byp, input logic [7:0] seed,
                              input string tag);
        int eff;
        logic [BW-1:0] b;
        logic [BW-1:0] ex;
        eff = (len < 1) ? 1 : len;
        ex  = '0;
        cfg_win_len = 32'(len);
        cfg_bypass  = byp;
        for (int k = 0; k < eff; k++) begin
            b  = mk_beat(seed, k);
            ex = (k == 0) ? b : smax(ex, b);
            @(negedge clk);
            in_valid  = 1'b1;
            in_data   = b;
            out_ready = 1'b0;
            #1;
            if (byp) begin
                chk(in_ready == 1'b0, "R7 ready", {511'b0, in_ready}, '0);
                chk(out_valid && out_data == b, "R7 data", out_data, b);
                @(negedge clk);
                out_ready = 1'b1;
                #1;
                chk(in_ready == 1'b1, "R7 ready", {511'b0, in_ready}, 1);
            end else if (k < eff - 1) begin
                chk(out_valid == 1'b0, {tag, " R3 early valid"}, {511'b0, out_valid}, '0);
                chk(in_ready == 1'b1, "R4 accum ready", {511'b0, in_ready}, 1);
            end else begin
                chk(in_ready == 1'b0, "R5 stall", {511'b0, in_ready}, '0);
                chk(out_valid == 1'b1, {tag, " R3 last valid"}, {511'b0, out_valid}, 1);
                @(negedge clk);
                out_ready = 1'b1;
                #1;
                chk(in_ready == 1'b1, "R5 release", {511'b0, in_ready}, 1);
                chk(out_data == ex, {tag, " result"}, out_data, ex);
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_win_len = 32'd9; cfg_bypass = 1'b0;
        in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R1 reset valid", {511'b0, out_valid}, '0);
        chk(in_ready == 1'b1, "R1 reset ready", {511'b0, in_ready}, 1);

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            string tag;
            if (VECS[v].byp)          tag = "R7";
            else if (VECS[v].len < 2) tag = "R8";
            else if (VECS[v].seed[7]) tag = "R6";
            else                      tag = "R2";
            run_window(int'(VECS[v].len), VECS[v].byp, VECS[v].seed, tag);
        end

        // R1: reset part-way through a window
        cfg_win_len = 32'd3; cfg_bypass = 1'b0;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = {NB{8'h7f}}; out_ready = 1'b1;
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 mid-window reset",
            {510'b0, out_valid, in_ready}, 2'b01);
        run_window(3, 1'b0, 8'ha1, "R1");

        // R9: signed comparison, -1 vs 1 and -128 vs 127
        begin
            logic [BW-1:0] pa, pb, ex;
            for (int j = 0; j < NB; j++) begin
                pa[j*8 +: 8] = j[0] ? 8'h80 : 8'hff;
                pb[j*8 +: 8] = j[0] ? 8'h7f : 8'h01;
            end
            ex = pb;
            cfg_win_len = 32'd2;
            @(negedge clk);
            in_valid = 1'b1; in_data = pa; out_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            in_data = pb;
            #1;
            chk(out_valid == 1'b1 && out_data == ex, "R9 signed max", out_data, ex);
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
        end

        // R6 again: negative-only window directly after the R9 positives
        run_window(2, 1'b0, 8'hc3, "R6");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule